// File: doc/BRIEF.md
# Shared-Bus SCL Clock Synchronizer

This block produces the serial clock for a two-wire bus master when several masters share the clock line. The clock line is open-drain: any device pulling it low wins. The block pulls the line low through an enable and counts a programmed low time. Counting starts only once the block sees the line low. It then lets go of the line and waits until it reads the line high. Only then does it count the programmed high time.

Because the block times its phases from the line it observes, the phases combine across devices. A slower device that keeps the line low stretches the low phase. A device that pulls the line low during the high phase ends that phase early. On that early fall the block starts its own low count at once.

The block gives the byte engine a one-cycle strobe at the start of each high phase and another at each moment it begins to pull the line low. The engine uses these strobes to place data changes and data samples. The clock-line input is synchronized inside the block. The two period counts can be changed at run time and are read each time a phase starts.

Top module: `scl_clock_sync`

## Requirements
- R1: During and after reset, with `en` low, `scl_drive_low` is 0 and both strobes are 0.
- R2: One clock after `en` is sampled low, the block is idle: `scl_drive_low` is 0 and no strobe is issued while `en` stays low.
- R3: On enable, or when the high count expires, the block asserts `scl_drive_low`, and `fall_tick` is 1 in that first cycle. Low counting starts only once the two-stage synchronized line reads 0. With no other device on the bus, the drive lasts 3 + max(low_cnt,1) clocks.
- R4: After the low count, the block releases the line and waits for as long as the line is held low. The high phase starts on the first clock at which the synchronized line reads 1. `rise_tick` is 1 in the first high cycle, which is 3 clocks after the line goes high.
- R5: With no other device on the bus, the high phase lasts max(high_cnt,1) clocks, and then the block pulls low again (R3).
- R6: If the synchronized line reads 0 during the high phase, the block pulls low on the next clock with `fall_tick`, and the drive lasts max(low_cnt,1) clocks.
- R7: Each strobe lasts one cycle, and the two strobes are never high together.
- R8: `low_cnt` and `high_cnt` are read when the matching phase starts, so a change applies from the next phase.
- R9: If another device holds the line low past this block's own low count, the high phase and `rise_tick` wait until 3 clocks after the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the clock generator |
| low_cnt | input | CNT_W | Low period, in system clocks |
| high_cnt | input | CNT_W | High period, in system clocks |
| scl_in | input | 1 | Raw clock-line level read from the pad |
| scl_drive_low | output | 1 | 1 = pull the clock line low (open-drain enable) |
| rise_tick | output | 1 | One-cycle strobe at the start of the high phase |
| fall_tick | output | 1 | One-cycle strobe when the block starts pulling low |

## Verification
The bench builds the block with CNT_W = 8 and two synchronizer stages. With CNT_W = 8, both the zero count and the largest count of 255 can be tested, so the max(N,1) rule and the long-count path are exercised in a few hundred cycles. The bench models the wired-AND line as its own pull-low combined with a second device's pull-low. This lets it stretch the low phase and cut the high phase short at chosen cycle offsets. Each phase length and strobe position is then compared against values derived from the three-cycle synchronization and wait latency.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PULL,
        PH_LOW,
        PH_WAIT,
        PH_HIGH
    } scl_phase_e;

    typedef struct packed {
        logic load;
        logic sel_high;
    } cnt_ctrl_t;

    function automatic logic phase_drives(input scl_phase_e ph);
        return (ph == PH_PULL) || (ph == PH_LOW);
    endfunction

endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= 1'b1;
                else     s_q <= d;
            end
            assign q = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] sh_q;
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '1;
                else     sh_q <= {sh_q[STAGES-2:0], d};
            end
            assign q = sh_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
    end

    assign last = (cnt_q <= ONE);
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      scl_seen,
    input  logic      cnt_last,
    output cnt_ctrl_t cnt_ctrl,
    output logic      drive_low,
    output logic      rise_tick,
    output logic      fall_tick
);
    scl_phase_e ph_q, ph_d;
    logic       rise_q, fall_q;

    always_comb begin
        ph_d     = ph_q;
        cnt_ctrl = '0;
        unique case (ph_q)
            PH_IDLE: ph_d = PH_PULL;
            PH_PULL: if (!scl_seen) begin
                ph_d     = PH_LOW;
                cnt_ctrl = '{load: 1'b1, sel_high: 1'b0};
            end
            PH_LOW:  if (cnt_last) ph_d = PH_WAIT;
            PH_WAIT: if (scl_seen) begin
                ph_d     = PH_HIGH;
                cnt_ctrl = '{load: 1'b1, sel_high: 1'b1};
            end
            PH_HIGH: if (!scl_seen) begin
                ph_d     = PH_LOW;
                cnt_ctrl = '{load: 1'b1, sel_high: 1'b0};
            end else if (cnt_last) begin
                ph_d = PH_PULL;
            end
            default: ph_d = PH_IDLE;
        endcase
        if (!en) begin
            ph_d     = PH_IDLE;
            cnt_ctrl = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            rise_q <= (ph_d == PH_HIGH) && (ph_q != PH_HIGH);
            fall_q <= phase_drives(ph_d) && !phase_drives(ph_q);
        end
    end

    assign drive_low = phase_drives(ph_q);
    assign rise_tick = rise_q;
    assign fall_tick = fall_q;
endmodule

// File: rtl/scl_clock_sync.sv
module scl_clock_sync
    import scl_sync_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic      scl_seen;
    logic      cnt_last;
    cnt_ctrl_t cnt_ctrl;

    scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (scl_in),
        .q   (scl_seen)
    );

    scl_phase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_ctrl.load),
        .load_val (cnt_ctrl.sel_high ? high_cnt : low_cnt),
        .last     (cnt_last)
    );

    scl_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .scl_seen  (scl_seen),
        .cnt_last  (cnt_last),
        .cnt_ctrl  (cnt_ctrl),
        .drive_low (scl_drive_low),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );
endmodule

// File: rtl/scl_clock_sync_chk.sv
module scl_clock_sync_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic scl_seen,
    input logic scl_drive_low,
    input logic rise_tick,
    input logic fall_tick
);
    // R2: disabled block goes quiet one clock later
    p_disable_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!scl_drive_low && !rise_tick && !fall_tick));

    // R3: every fall strobe coincides with the pull-low drive
    p_fall_with_drive_r3: assert property (@(posedge clk) disable iff (rst)
        fall_tick |-> scl_drive_low);

    // R3: drive never starts without its strobe
    p_drive_start_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_drive_low) |-> fall_tick);

    // R4: high phase only begins after the line was seen high, while released
    p_rise_on_high_r4: assert property (@(posedge clk) disable iff (rst)
        rise_tick |-> (!scl_drive_low && $past(scl_seen)));

    // R7: strobes are exclusive and single-cycle
    p_tick_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(rise_tick && fall_tick));

    p_rise_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rise_tick |=> !rise_tick);

    p_fall_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        fall_tick |=> !fall_tick);
endmodule

bind scl_clock_sync scl_clock_sync_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .scl_seen      (scl_seen),
    .scl_drive_low (scl_drive_low),
    .rise_tick     (rise_tick),
    .fall_tick     (fall_tick)
);

// File: tb/scl_clock_sync_tb.sv
module scl_clock_sync_tb;
    localparam int CNT_W = 8;
    localparam int NV    = 6;
    // {low_cnt, high_cnt, expected release idx, expected rise idx, expected next fall idx}
    localparam int VEC [NV][5] = '{
        '{4,   5,  7,   10,  15},
        '{1,   1,  4,   7,   8},
        '{0,   0,  4,   7,   8},
        '{9,   2,  12,  15,  17},
        '{2,   12, 5,   8,   20},
        '{255, 1,  258, 261, 262}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en  = 1'b0;
    logic [CNT_W-1:0] low_cnt  = '0;
    logic [CNT_W-1:0] high_cnt = '0;
    logic             ext_low  = 1'b0;
    logic             scl_in;
    logic             scl_drive_low, rise_tick, fall_tick;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    assign scl_in = ~(scl_drive_low | ext_low);

    scl_clock_sync #(.CNT_W(CNT_W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .en            (en),
        .low_cnt       (low_cnt),
        .high_cnt      (high_cnt),
        .scl_in        (scl_in),
        .scl_drive_low (scl_drive_low),
        .rise_tick     (rise_tick),
        .fall_tick     (fall_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure(output int t_rel, output int t_rise,
                           output int t_fall, output int n_rise);
        int k;
        t_rel = -1; t_rise = -1; t_fall = -1; n_rise = 0; k = 0;
        while (!fall_tick && k < 1000) begin
            @(negedge clk);
            k++;
        end
        for (int i = 1; i < 1000; i++) begin
            @(negedge clk);
            if (t_rel < 0 && !scl_drive_low) t_rel = i;
            if (rise_tick) begin
                n_rise++;
                if (t_rise < 0) t_rise = i;
            end
            if (fall_tick) begin
                t_fall = i;
                break;
            end
        end
    endtask

    task automatic stop_run();
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R2 drive after disable", int'(scl_drive_low), 0);
        chk("R2 strobes after disable", int'(rise_tick | fall_tick), 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int rel, rs, fl, nr;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 drive in reset", int'(scl_drive_low), 0);
        chk("R1 strobes in reset", int'(rise_tick | fall_tick), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 drive idle after reset", int'(scl_drive_low), 0);
        chk("R1 strobes idle after reset", int'(rise_tick | fall_tick), 0);

        // R3 R4 R5: vector table of uncontended periods
        for (int v = 0; v < NV; v++) begin
            low_cnt  = CNT_W'(VEC[v][0]);
            high_cnt = CNT_W'(VEC[v][1]);
            en = 1'b1;
            measure(rel, rs, fl, nr);
            chk("R3 low drive length", rel, VEC[v][2]);
            chk("R4 rise strobe position", rs, VEC[v][3]);
            chk("R5 next fall position", fl, VEC[v][4]);
            chk("R7 one rise per period", nr, 1);
            stop_run();
        end

        // R8: counts changed at run time apply from the next phase
        low_cnt = 8'd4; high_cnt = 8'd5; en = 1'b1;
        measure(rel, rs, fl, nr);
        low_cnt = 8'd6; high_cnt = 8'd2;
        measure(rel, rs, fl, nr);
        chk("R8 new low count", rel, 9);
        chk("R8 new rise position", rs, 12);
        chk("R8 new high count", fl, 14);
        stop_run();

        // R9: another device stretches the low phase
        low_cnt = 8'd2; high_cnt = 8'd4; en = 1'b1;
        while (!fall_tick) @(negedge clk);
        ext_low = 1'b1;
        rel = -1; rs = -1; nr = 0;
        for (int i = 1; i < 40; i++) begin
            @(negedge clk);
            if (rel < 0 && !scl_drive_low) rel = i;
            if (rise_tick) begin
                nr++;
                if (rs < 0) rs = i;
            end
            if (i == 20) ext_low = 1'b0;
            if (rs >= 0) break;
        end
        chk("R9 own release unaffected", rel, 5);
        chk("R9 rise waits for line release", rs, 23);
        chk("R9 single rise", nr, 1);
        stop_run();

        // R6: another device ends the high phase early
        low_cnt = 8'd3; high_cnt = 8'd30; en = 1'b1;
        measure(rel, rs, fl, nr);
        chk("R6 setup rise position", rs, 9);
        fl = -1; rel = -1; rs = -1;
        while (!rise_tick) @(negedge clk);
        for (int i = 1; i < 40; i++) begin
            @(negedge clk);
            if (i == 2) ext_low = 1'b1;
            if (i == 4) ext_low = 1'b0;
            if (fl < 0 && fall_tick) fl = i;
            if (fl >= 0 && rel < 0 && !scl_drive_low) rel = i;
            if (fl >= 0 && rise_tick) begin
                rs = i;
                break;
            end
        end
        chk("R6 early fall strobe", fl, 5);
        chk("R6 low drive length", rel - fl, 3);
        chk("R6 next rise", rs, 11);
        stop_run();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule